// File: doc/BRIEF.md
# Asymmetric Decode Group Steering

This block sits between an instruction queue and four decoders of unequal power. Each cycle it looks at a window of up to five predecoded descriptors, oldest first, and builds one decode group in program order. Slot 0 is the complex slot. It takes an instruction of one to four micro-ops. Slots 1 to 3 are simple and take only single micro-op instructions. A compare or test followed at once by a conditional branch is merged into one fused micro-op. Because of this, four slots can retire five instructions. An instruction whose memory read and arithmetic operation fold into one load-op micro-op counts one micro-op fewer.

An instruction that needs more than four micro-ops is not given a slot. It is removed from the queue and passed to a counter-based sequencer, which emits placeholder micro-ops four per cycle until its count runs out.

A state machine with two states controls the block. In DECODE the group former drives the outputs. DECODE goes to UCODE in a non-stalled cycle whose oldest instruction is oversized. In UCODE the sequencer drives the outputs and the queue is not read. UCODE goes back to DECODE in the non-stalled cycle in which the last chunk is emitted. The input side reports how many instructions it consumed. The output side presents a per-slot valid mask and can stall the block.

Top module: `decode_steer`

## Requirements
- R1: A descriptor is 12 bits: len [3:0] (1 to 15), ucnt [8:4] (raw micro-op count), mem [9], cmp_head [10], br_tail [11]. Window position i occupies bits [12*i+11:12*i]. `out_bytes` is the sum of the len fields of the instructions consumed by the group. It is zero in UCODE.
- R2: The valid mask always has the form 2^k-1 (slots filled from slot 0 up). Invalid slots report kind, src and nuop as 0.
- R3: Slots 1 to 3 hold only records of one micro-op. If an instruction with an effective count other than 1 reaches a later position, the group ends before it.
- R4: Slot 0 accepts an instruction with an effective count from 1 to 4. It reports kind COMPLEX (1) with nuop equal to that count when the count is above 1, and kind SIMPLE (0) when the count is 1. `out_src` gives the window index of the record's first instruction.
- R5: If the oldest instruction's effective count exceeds 4, the cycle emits no record, consumes exactly that one instruction, and enters UCODE.
- R6: In UCODE each non-stalled cycle emits min(4, remaining) records of kind MCODE (3) with nuop 1 and src 0, and consumes nothing. After the last chunk the block returns to DECODE.
- R7: When a cmp_head instruction of effective count 1 is followed inside the available window by a br_tail instruction, both form one FUSED (2) record with nuop 1 and consume two instructions. A group can therefore consume 5 instructions.
- R8: At most one fusion happens per group. A second fusible pair ends the group before its head, so the pair is never split.
- R9: The effective count is ucnt-1 when mem is set and ucnt>1; otherwise it is ucnt. A load-op with a separate store (ucnt 3, mem) therefore counts 2.
- R10: While `out_ready` is low, `in_take` is 0 and the state and sequencer count hold. The same outputs are presented again in the next cycle.
- R11: After reset the block is in DECODE. With an empty window it shows no valid slot, zero take and zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_avail | input | 3 | Number of valid descriptors in the window (0 to 5) |
| in_win | input | 60 | Five descriptors, oldest at position 0 |
| in_take | output | 3 | Instructions consumed this cycle |
| out_ready | input | 1 | Downstream accepts the group this cycle |
| out_valid | output | 4 | Per-slot valid mask |
| out_kind | output | 8 | 2-bit kind per slot: 0 SIMPLE, 1 COMPLEX, 2 FUSED, 3 MCODE |
| out_nuop | output | 12 | 3-bit micro-op count per slot |
| out_src | output | 12 | 3-bit window index per slot |
| out_bytes | output | 7 | Total byte length consumed by the group |

## Verification
The hardest case to reach is a downstream stall that arrives in the middle of a sequencer run. The sequencer count must survive the stall cycle, and the same chunk must appear again. The stimulus first lets an oversized instruction be consumed. It then lets one chunk through, drops `out_ready` for one cycle, and checks that the remaining chunks are a full chunk followed by the two-record tail. A second hard case is a window holding two fusible pairs, or a pair that lands in the last simple slot. These cases show whether the group ends before the second head or fuses into slot 3.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
    localparam int LEN_W   = 4;
    localparam int UCNT_W  = 5;
    localparam int DESC_W  = LEN_W + UCNT_W + 3;
    localparam int WIN     = 5;
    localparam int NSLOT   = 4;
    localparam int MAXCPX  = 4;
    localparam int IDX_W   = $clog2(WIN + 1);
    localparam int SRC_W   = $clog2(WIN);
    localparam int NUOP_W  = $clog2(MAXCPX + 1);
    localparam int BYTES_W = $clog2(WIN * 15 + 1);

    typedef enum logic [1:0] {K_SIMPLE, K_COMPLEX, K_FUSED, K_MCODE} kind_e;

    typedef struct packed {
        logic              br_tail;
        logic              cmp_head;
        logic              mem;
        logic [UCNT_W-1:0] ucnt;
        logic [LEN_W-1:0]  len;
    } desc_t;

    function automatic logic [UCNT_W-1:0] eff_uops(input desc_t d);
        return (d.mem && d.ucnt > UCNT_W'(1)) ? d.ucnt - UCNT_W'(1) : d.ucnt;
    endfunction
endpackage

// File: rtl/group_former.sv
module group_former
    import dgs_pkg::*;
(
    input  desc_t               win [WIN],
    input  logic [IDX_W-1:0]    avail,
    output logic [IDX_W-1:0]    take,
    output logic [NSLOT-1:0]    valid,
    output logic [2*NSLOT-1:0]  kind,
    output logic [NUOP_W*NSLOT-1:0] nuop,
    output logic [SRC_W*NSLOT-1:0]  src,
    output logic [BYTES_W-1:0]  bytes,
    output logic                mc_start,
    output logic [UCNT_W-1:0]   mc_cnt
);
    always_comb begin
        logic [3:0]        ptr;
        logic [3:0]        nidx;
        logic              fused_used;
        logic              stop;
        desc_t             cur;
        desc_t             nxt;
        logic [UCNT_W-1:0] e;
        ptr        = '0;
        nidx       = '0;
        fused_used = 1'b0;
        stop       = 1'b0;
        cur        = '0;
        nxt        = '0;
        e          = '0;
        valid      = '0;
        kind       = '0;
        nuop       = '0;
        src        = '0;
        bytes      = '0;
        mc_start   = 1'b0;
        mc_cnt     = '0;
        for (int s = 0; s < NSLOT; s++) begin
            nidx = ptr + 4'd1;
            cur  = (ptr < 4'(WIN))  ? win[ptr[2:0]]  : '0;
            nxt  = (nidx < 4'(WIN)) ? win[nidx[2:0]] : '0;
            e    = eff_uops(cur);
            if (!stop) begin
                if (ptr >= 4'(avail)) begin
                    stop = 1'b1;
                end else if (s == 0 && e > UCNT_W'(MAXCPX)) begin
                    mc_start = 1'b1;
                    mc_cnt   = e;
                    bytes    = BYTES_W'(cur.len);
                    ptr      = 4'd1;
                    stop     = 1'b1;
                end else if (s != 0 && e != UCNT_W'(1)) begin
                    stop = 1'b1;
                end else if (e == UCNT_W'(1) && cur.cmp_head &&
                             nidx < 4'(avail) && nxt.br_tail) begin
                    if (fused_used) begin
                        stop = 1'b1;
                    end else begin
                        valid[s]               = 1'b1;
                        kind[2*s +: 2]         = K_FUSED;
                        nuop[NUOP_W*s +: NUOP_W] = NUOP_W'(1);
                        src[SRC_W*s +: SRC_W]  = ptr[SRC_W-1:0];
                        bytes = bytes + BYTES_W'(cur.len) + BYTES_W'(nxt.len);
                        ptr        = ptr + 4'd2;
                        fused_used = 1'b1;
                    end
                end else begin
                    valid[s]               = 1'b1;
                    kind[2*s +: 2]         = (e == UCNT_W'(1)) ? K_SIMPLE : K_COMPLEX;
                    nuop[NUOP_W*s +: NUOP_W] = e[NUOP_W-1:0];
                    src[SRC_W*s +: SRC_W]  = ptr[SRC_W-1:0];
                    bytes = bytes + BYTES_W'(cur.len);
                    ptr   = ptr + 4'd1;
                end
            end
        end
        take = ptr[IDX_W-1:0];
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import dgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [UCNT_W-1:0] load_cnt,
    input  logic              adv,
    output logic              active,
    output logic              last,
    output logic [NUOP_W-1:0] chunk
);
    logic [UCNT_W-1:0] cnt_q;

    assign active = (cnt_q != '0);
    assign chunk  = (cnt_q > UCNT_W'(MAXCPX)) ? NUOP_W'(MAXCPX) : cnt_q[NUOP_W-1:0];
    assign last   = active && (cnt_q <= UCNT_W'(MAXCPX));

    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_cnt;
        else if (adv && active)   cnt_q <= cnt_q - UCNT_W'(chunk);
    end

    // R10
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cnt_q));
    // R5
    seq_load_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q > UCNT_W'(MAXCPX)));
endmodule

// File: rtl/decode_steer.sv
module decode_steer
    import dgs_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        in_avail,
    input  logic [WIN*DESC_W-1:0]   in_win,
    output logic [IDX_W-1:0]        in_take,
    input  logic                    out_ready,
    output logic [NSLOT-1:0]        out_valid,
    output logic [2*NSLOT-1:0]      out_kind,
    output logic [NUOP_W*NSLOT-1:0] out_nuop,
    output logic [SRC_W*NSLOT-1:0]  out_src,
    output logic [BYTES_W-1:0]      out_bytes
);
    typedef enum logic {ST_DECODE, ST_UCODE} state_e;
    state_e state_q, state_d;

    desc_t win [WIN];
    for (genvar i = 0; i < WIN; i++) begin : g_unpack
        assign win[i] = desc_t'(in_win[DESC_W*i +: DESC_W]);
        // R1
        len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_DECODE && in_avail > IDX_W'(i)) |-> (win[i].len != '0));
    end

    logic [IDX_W-1:0]        g_take;
    logic [NSLOT-1:0]        g_valid;
    logic [2*NSLOT-1:0]      g_kind;
    logic [NUOP_W*NSLOT-1:0] g_nuop;
    logic [SRC_W*NSLOT-1:0]  g_src;
    logic [BYTES_W-1:0]      g_bytes;
    logic                    mc_start;
    logic [UCNT_W-1:0]       mc_cnt;
    logic                    sq_active, sq_last, sq_load, sq_adv;
    logic [NUOP_W-1:0]       sq_chunk;

    group_former u_form (
        .win(win), .avail(in_avail), .take(g_take), .valid(g_valid),
        .kind(g_kind), .nuop(g_nuop), .src(g_src), .bytes(g_bytes),
        .mc_start(mc_start), .mc_cnt(mc_cnt)
    );

    assign sq_load = (state_q == ST_DECODE) && out_ready && mc_start;
    assign sq_adv  = (state_q == ST_UCODE) && out_ready;

    ucode_seq u_seq (
        .clk(clk), .rst_n(rst_n), .load(sq_load), .load_cnt(mc_cnt),
        .adv(sq_adv), .active(sq_active), .last(sq_last), .chunk(sq_chunk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DECODE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DECODE: if (out_ready && mc_start) state_d = ST_UCODE;
            ST_UCODE:  if (out_ready && sq_last)  state_d = ST_DECODE;
        endcase
    end

    always_comb begin
        in_take   = '0;
        out_valid = '0;
        out_kind  = '0;
        out_nuop  = '0;
        out_src   = '0;
        out_bytes = '0;
        unique case (state_q)
            ST_DECODE: begin
                in_take   = out_ready ? g_take : '0;
                out_valid = g_valid;
                out_kind  = g_kind;
                out_nuop  = g_nuop;
                out_src   = g_src;
                out_bytes = g_bytes;
            end
            ST_UCODE: begin
                for (int s = 0; s < NSLOT; s++) begin
                    if (NUOP_W'(s) < sq_chunk) begin
                        out_valid[s]                 = 1'b1;
                        out_kind[2*s +: 2]           = K_MCODE;
                        out_nuop[NUOP_W*s +: NUOP_W] = NUOP_W'(1);
                    end
                end
            end
        endcase
    end

    // R6
    ucode_state_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UCODE) == sq_active);
    // R6
    ucode_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UCODE) |-> (in_take == '0 && out_bytes == '0));
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> $stable(state_q));
    // R2
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + NSLOT'(1))) == '0));
    // R7
    take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_take <= in_avail);
    for (genvar s = 1; s < NSLOT; s++) begin : g_simple
        // R3
        simple_one_uop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[s] |-> (out_nuop[NUOP_W*s +: NUOP_W] == NUOP_W'(1)));
    end
endmodule

// File: tb/decode_steer_bench.sv
module decode_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  in_avail = '0;
    logic [59:0] in_win = '0;
    logic [2:0]  in_take;
    logic        out_ready = 1'b1;
    logic [3:0]  out_valid;
    logic [7:0]  out_kind;
    logic [11:0] out_nuop;
    logic [11:0] out_src;
    logic [6:0]  out_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    decode_steer u_decode_steer (
        .clk(clk), .rst_n(rst_n), .in_avail(in_avail), .in_win(in_win),
        .in_take(in_take), .out_ready(out_ready), .out_valid(out_valid),
        .out_kind(out_kind), .out_nuop(out_nuop), .out_src(out_src),
        .out_bytes(out_bytes)
    );

    typedef struct {
        int          take;
        logic [3:0]  mask;
        logic [7:0]  kind;
        logic [11:0] nuop;
        logic [11:0] src;
        int          bytes;
        string       tag;
    } exp_t;

    exp_t sb[$];
    event go;

    function automatic logic [11:0] dsc(int len, int ucnt, bit mem, bit hd, bit tl);
        return {tl, hd, mem, 5'(ucnt), 4'(len)};
    endfunction
    function automatic logic [11:0] sm(int len);
        return dsc(len, 1, 0, 0, 0);
    endfunction

    task automatic drive(int avail, logic [59:0] w, bit rdy, int take, logic [3:0] mask,
                         logic [7:0] kind, logic [11:0] nuop, logic [11:0] src,
                         int bytes, string tag);
        exp_t e;
        @(negedge clk);
        in_avail  = 3'(avail);
        in_win    = w;
        out_ready = rdy;
        e.take = take; e.mask = mask; e.kind = kind; e.nuop = nuop;
        e.src = src; e.bytes = bytes; e.tag = tag;
        sb.push_back(e);
        ->go;
    endtask

    initial begin
        forever begin
            exp_t e;
            @(go);
            #1;
            e = sb.pop_front();
            checks++;
            if (int'(in_take) != e.take || out_valid != e.mask || out_kind != e.kind ||
                out_nuop != e.nuop || out_src != e.src || int'(out_bytes) != e.bytes) begin
                errors++;
                $display("FAIL %s: take=%0d valid=%b kind=%h nuop=%o src=%o bytes=%0d expected take=%0d valid=%b kind=%h nuop=%o src=%o bytes=%0d",
                         e.tag, in_take, out_valid, out_kind, out_nuop, out_src, out_bytes,
                         e.take, e.mask, e.kind, e.nuop, e.src, e.bytes);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] hd1, tl1;
        hd1 = dsc(1, 1, 0, 1, 0);
        tl1 = dsc(1, 1, 0, 0, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        drive(0, '0, 1, 0, 4'h0, 8'h00, 12'o0000, 12'o0000, 0, "R11 reset");
        // R3 four simples fill all slots
        drive(5, {sm(5), sm(4), sm(3), sm(2), sm(1)}, 1, 4, 4'hf, 8'h00, 12'o1111, 12'o3210, 10, "R3 simples");
        // R10 stall in decode: shown but not taken
        drive(5, {sm(5), sm(4), sm(3), sm(2), sm(1)}, 0, 0, 4'hf, 8'h00, 12'o1111, 12'o3210, 10, "R10 decode stall");
        // R4 complex in slot 0
        drive(5, {sm(1), sm(1), sm(1), sm(1), dsc(6, 3, 0, 0, 0)}, 1, 4, 4'hf, 8'h01, 12'o1113, 12'o3210, 9, "R4 complex slot");
        // R3 multi-uop in later slot ends group
        drive(2, {36'd0, dsc(3, 2, 0, 0, 0), sm(2)}, 1, 1, 4'h1, 8'h00, 12'o0001, 12'o0000, 2, "R3 group break");
        // R7 fusion, five instructions
        drive(5, {sm(5), sm(4), dsc(3, 1, 0, 0, 1), dsc(2, 1, 0, 1, 0), sm(1)}, 1, 5, 4'hf, 8'h08, 12'o1111, 12'o4310, 15, "R7 five consumed");
        // R8 second pair ends group
        drive(5, {sm(1), tl1, hd1, tl1, hd1}, 1, 2, 4'h1, 8'h02, 12'o0001, 12'o0000, 2, "R8 one fusion");
        // R7 fusion in last slot
        drive(5, {tl1, hd1, sm(1), sm(1), sm(1)}, 1, 5, 4'hf, 8'h80, 12'o1111, 12'o3210, 5, "R7 slot3 fusion");
        // R7 head without tail present
        drive(1, {48'd0, dsc(3, 1, 0, 1, 0)}, 1, 1, 4'h1, 8'h00, 12'o0001, 12'o0000, 3, "R7 lone head");
        // R9 load-op in simple slot
        drive(3, {24'd0, dsc(5, 2, 0, 0, 0), dsc(4, 2, 1, 0, 0), sm(1)}, 1, 2, 4'h3, 8'h00, 12'o0011, 12'o0010, 5, "R9 load-op simple");
        // R9 load-op plus store counts 2
        drive(1, {48'd0, dsc(7, 3, 1, 0, 0)}, 1, 1, 4'h1, 8'h01, 12'o0002, 12'o0000, 7, "R9 load-op store");
        // R4 boundary count 4
        drive(1, {48'd0, dsc(8, 5, 1, 0, 0)}, 1, 1, 4'h1, 8'h01, 12'o0004, 12'o0000, 8, "R4 four uops");
        // R2 partial window
        drive(3, {24'd0, sm(1), sm(1), sm(1)}, 1, 3, 4'h7, 8'h00, 12'o0111, 12'o0210, 3, "R2 partial");
        // R5 microcode entry
        drive(2, {36'd0, sm(1), dsc(9, 10, 0, 0, 0)}, 1, 1, 4'h0, 8'h00, 12'o0000, 12'o0000, 9, "R5 mcode entry");
        // R6 sequencer chunks
        drive(2, {36'd0, sm(1), sm(1)}, 1, 0, 4'hf, 8'hff, 12'o1111, 12'o0000, 0, "R6 chunk1");
        drive(2, {36'd0, sm(1), sm(1)}, 0, 0, 4'hf, 8'hff, 12'o1111, 12'o0000, 0, "R10 ucode stall");
        drive(2, {36'd0, sm(1), sm(1)}, 1, 0, 4'hf, 8'hff, 12'o1111, 12'o0000, 0, "R6 chunk2");
        drive(2, {36'd0, sm(1), sm(1)}, 1, 0, 4'h3, 8'h0f, 12'o0011, 12'o0000, 0, "R6 tail chunk");
        // R6 back to decode
        drive(1, {48'd0, sm(2)}, 1, 1, 4'h1, 8'h00, 12'o0001, 12'o0000, 2, "R6 resume");
        // R11 empty window again
        drive(0, '0, 1, 0, 4'h0, 8'h00, 12'o0000, 12'o0000, 0, "R11 empty");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule